// File: doc/BRIEF.md
# Pending Request Table with Two Hashed Sub-Tables

This block keeps track of content requests that a router line card has forwarded but not yet seen answered. Every pending entry is identified by a 32-bit fingerprint of the content name. The entry holds a pointer to the place where the full name is stored, a bitmap of the arrival ports that asked for the content, the nonce of the first request, and an expiry time. Entries live in two hashed sub-tables. Each sub-table has one candidate bucket per fingerprint, and a lookup is an exact comparison of the fingerprint against the stored key.

Commands arrive one at a time through a valid/ready pair. A request either creates an entry or merges its port into an existing one. A request that carries the nonce of the first request is reported as a loop and changes nothing. A response returns and frees the matching entry. A tick advances a 16-bit time counter. Each command produces a single-cycle result pulse. The pulse carries hit, loop and full flags and, for a response hit, the stored port set and name pointer.

A build-time switch selects how the two sub-tables are probed. They can be probed one after the other, which models a single-ported memory, or both in the same cycle. When no command is presented, a background sweeper visits one slot per cycle and frees the slot if its entry has expired.

Top module: `pending_table`

## Requirements
- R1: After reset, `cmd_ready` is 1, `res_valid` is 0 and the table is empty. The command code `cmd_op` is 0 for request, 1 for response, and 2 or 3 for tick.
- R2: Lookup is an exact match on the whole fingerprint. With k = IDX_W, sub-table 0 uses fingerprint bits [k-1:0] as its bucket index and sub-table 1 uses bits [2k-1:k]. A fingerprint that shares both bucket indices with a stored entry but differs in any other bit does not match it.
- R3: A request that matches no live entry stores a new entry. The new entry holds port bit `1 << cmd_port`, `cmd_nonce`, `cmd_ptr` and expiry = tick count + `cfg_life`. It goes to the sub-table 0 bucket if that bucket is free, and otherwise to the sub-table 1 bucket. The result has hit=0, loop=0, full=0.
- R4: A request that misses while both candidate buckets hold live entries returns full=1 and hit=0, and stores nothing.
- R5: A request that hits with a nonce different from the stored one returns hit=1 and ORs its port bit into the stored port set. It creates no second entry.
- R6: A request that hits with a nonce equal to the stored one returns hit=1 and loop=1, and leaves the entry unchanged.
- R7: A response that hits returns hit=1, the stored port set on `res_ports` and the stored pointer on `res_ptr`, and frees the entry. A response that misses returns hit=0 with `res_ports` and `res_ptr` both 0.
- R8: An entry is live while the signed 16-bit value (tick count − expiry) is at most 0. Once that value is positive, every command treats the entry as absent.
- R9: On each cycle with no command presented, the sweeper checks one slot and frees it if it has expired. As a result, an expired entry does not reappear after the tick counter has moved on by 2^15.
- R10: `res_valid` rises in the cycle that starts N rising edges after the edge that accepted the command. For a tick, N=1, and `cmd_ready` stays high. With sequential probing, N=2 for a hit in sub-table 0 and N=3 for every other request or response. With parallel probing, N=2. `cmd_ready` is low while a request or response is in progress.
- R11: Each command yields a `res_valid` pulse of exactly one cycle. `res_hit` and `res_full` are never 1 together. A tick result has hit, loop and full all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 2 | 0 request, 1 response, 2/3 tick |
| cmd_key | input | KEY_W | Name fingerprint |
| cmd_port | input | PW | Arrival port number of a request |
| cmd_nonce | input | NONCE_W | Request nonce |
| cmd_ptr | input | PTR_W | Pointer to the stored name |
| cfg_life | input | TICK_W | Lifetime added to the tick count on insert |
| res_valid | output | 1 | Result pulse |
| res_hit | output | 1 | Fingerprint matched a live entry |
| res_loop | output | 1 | Request nonce repeated |
| res_full | output | 1 | Insert refused, both buckets live |
| res_ports | output | NPORT | Port set returned by a response hit |
| res_ptr | output | PTR_W | Pointer returned by a response hit |

## Verification
The bench builds the block with IDX_W=3 and sequential probing. Eight buckets per sub-table make it easy to fill both candidate buckets of a fingerprint, so full results and sub-table 1 placement show up often under random keys drawn from a small pool. Sequential probing exposes both the short and the long result latency. Directed cases cover the expiry boundary tick and a run of 32768 ticks after one entry has expired, which would bring the entry back if the sweeper failed to clear it.

// File: rtl/pending_table.sv
module pending_table #(
  parameter int IDX_W    = 4,
  parameter int KEY_W    = 32,
  parameter int PTR_W    = 32,
  parameter int TICK_W   = 16,
  parameter int NONCE_W  = 16,
  parameter int NPORT    = 16,
  parameter int PARALLEL = 0,
  localparam int PW      = $clog2(NPORT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic [KEY_W-1:0]   cmd_key,
  input  logic [PW-1:0]      cmd_port,
  input  logic [NONCE_W-1:0] cmd_nonce,
  input  logic [PTR_W-1:0]   cmd_ptr,
  input  logic [TICK_W-1:0]  cfg_life,
  output logic               res_valid,
  output logic               res_hit,
  output logic               res_loop,
  output logic               res_full,
  output logic [NPORT-1:0]   res_ports,
  output logic [PTR_W-1:0]   res_ptr
);
  localparam int NB = 1 << IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_P0, S_P1} st_t;
  st_t st_q;

  logic               v_q     [2][NB];
  logic [KEY_W-1:0]   key_q   [2][NB];
  logic [PTR_W-1:0]   ptr_q   [2][NB];
  logic [NONCE_W-1:0] nonce_q [2][NB];
  logic [NPORT-1:0]   ports_q [2][NB];
  logic [TICK_W-1:0]  exp_q   [2][NB];

  logic [TICK_W-1:0]  now_q;
  logic [IDX_W:0]     sw_q;
  logic               c_rsp;
  logic [KEY_W-1:0]   c_key;
  logic [PW-1:0]      c_port;
  logic [NONCE_W-1:0] c_nonce;
  logic [PTR_W-1:0]   c_ptr;
  logic               p0_live_q, p0_match_q;

  function automatic logic past_due(input logic [TICK_W-1:0] e, input logic [TICK_W-1:0] t);
    logic signed [TICK_W-1:0] d;
    d = t - e;
    return d > 0;
  endfunction

  logic [IDX_W-1:0] i0, i1, hi, ii, sw_i;
  logic live0_rd, live1, match0_rd, match1, live0, match0;
  logic act, hit, ht, it, room, same_nonce, accept, sweep, sw_t;
  logic [NPORT-1:0] port_bit;

  assign i0        = c_key[IDX_W-1:0];
  assign i1        = c_key[2*IDX_W-1:IDX_W];
  assign live0_rd  = v_q[0][i0] && !past_due(exp_q[0][i0], now_q);
  assign live1     = v_q[1][i1] && !past_due(exp_q[1][i1], now_q);
  assign match0_rd = live0_rd && (key_q[0][i0] == c_key);
  assign match1    = live1 && (key_q[1][i1] == c_key);

  generate
    if (PARALLEL != 0) begin : g_par
      assign live0  = live0_rd;
      assign match0 = match0_rd;
      assign act    = (st_q == S_P0);
    end else begin : g_seq
      assign live0  = (st_q == S_P0) ? live0_rd : p0_live_q;
      assign match0 = (st_q == S_P0) ? match0_rd : p0_match_q;
      assign act    = (st_q == S_P1) || (st_q == S_P0 && match0_rd);
    end
  endgenerate

  assign hit        = match0 || match1;
  assign ht         = !match0;
  assign hi         = match0 ? i0 : i1;
  assign same_nonce = (nonce_q[ht][hi] == c_nonce);
  assign room       = !live0 || !live1;
  assign it         = live0;
  assign ii         = live0 ? i1 : i0;
  assign port_bit   = {{(NPORT-1){1'b0}}, 1'b1} << c_port;

  assign cmd_ready = (st_q == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign sweep     = (st_q == S_IDLE) && !cmd_valid;
  assign sw_t      = sw_q[IDX_W];
  assign sw_i      = sw_q[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      now_q      <= '0;
      sw_q       <= '0;
      p0_live_q  <= 1'b0;
      p0_match_q <= 1'b0;
      c_rsp      <= 1'b0;
      c_key      <= '0;
      c_port     <= '0;
      c_nonce    <= '0;
      c_ptr      <= '0;
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_loop   <= 1'b0;
      res_full   <= 1'b0;
      res_ports  <= '0;
      res_ptr    <= '0;
      for (int t = 0; t < 2; t++)
        for (int i = 0; i < NB; i++)
          v_q[t][i] <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (accept) begin
            if (cmd_op[1]) begin
              now_q     <= now_q + 1'b1;
              res_valid <= 1'b1;
              res_hit   <= 1'b0;
              res_loop  <= 1'b0;
              res_full  <= 1'b0;
              res_ports <= '0;
              res_ptr   <= '0;
            end else begin
              c_rsp   <= cmd_op[0];
              c_key   <= cmd_key;
              c_port  <= cmd_port;
              c_nonce <= cmd_nonce;
              c_ptr   <= cmd_ptr;
              st_q    <= S_P0;
            end
          end else if (sweep) begin
            if (v_q[sw_t][sw_i] && past_due(exp_q[sw_t][sw_i], now_q))
              v_q[sw_t][sw_i] <= 1'b0;
            sw_q <= sw_q + 1'b1;
          end
        end
        S_P0, S_P1: begin
          if (!act) begin
            p0_live_q  <= live0_rd;
            p0_match_q <= match0_rd;
            st_q       <= S_P1;
          end else begin
            st_q      <= S_IDLE;
            res_valid <= 1'b1;
            res_hit   <= hit;
            res_loop  <= 1'b0;
            res_full  <= 1'b0;
            res_ports <= '0;
            res_ptr   <= '0;
            if (!c_rsp) begin
              if (hit) begin
                if (same_nonce) res_loop <= 1'b1;
                else ports_q[ht][hi] <= ports_q[ht][hi] | port_bit;
              end else if (room) begin
                v_q[it][ii]     <= 1'b1;
                key_q[it][ii]   <= c_key;
                ptr_q[it][ii]   <= c_ptr;
                nonce_q[it][ii] <= c_nonce;
                ports_q[it][ii] <= port_bit;
                exp_q[it][ii]   <= now_q + cfg_life;
              end else begin
                res_full <= 1'b1;
              end
            end else if (hit) begin
              res_ports   <= ports_q[ht][hi];
              res_ptr     <= ptr_q[ht][hi];
              v_q[ht][hi] <= 1'b0;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pending_table_chk.sv
module pending_table_chk #(
  parameter int NPORT = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic             c_rsp,
  input logic             res_valid,
  input logic             res_hit,
  input logic             res_loop,
  input logic             res_full,
  input logic [NPORT-1:0] res_ports
);
  logic tick_acc, work_acc;
  assign tick_acc = cmd_valid && cmd_ready && cmd_op[1];
  assign work_acc = cmd_valid && cmd_ready && !cmd_op[1];

  assert_hit_full_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_hit && res_full));

  assert_loop_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_loop) |-> (res_hit && !res_full));

  assert_rsp_ports_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit && c_rsp) |-> (res_ports != '0));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    work_acc |=> !cmd_ready);

  assert_tick_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tick_acc |=> (res_valid && cmd_ready && !res_hit && !res_loop && !res_full));

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !tick_acc) |=> !res_valid);

  assert_result_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> cmd_ready);
endmodule

bind pending_table pending_table_chk #(.NPORT(NPORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .c_rsp(c_rsp), .res_valid(res_valid), .res_hit(res_hit),
  .res_loop(res_loop), .res_full(res_full), .res_ports(res_ports)
);

// File: tb/pending_table_test.sv
`timescale 1ns/1ps
module pending_table_test;
  localparam int IDX_W = 3;
  localparam int NB    = 1 << IDX_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [31:0] cmd_key = '0;
  logic [3:0]  cmd_port = '0;
  logic [15:0] cmd_nonce = '0;
  logic [31:0] cmd_ptr = '0;
  logic [15:0] cfg_life = 16'd10;
  logic        res_valid, res_hit, res_loop, res_full;
  logic [15:0] res_ports;
  logic [31:0] res_ptr;

  always #10 clk = ~clk;

  pending_table #(.IDX_W(IDX_W), .PARALLEL(0)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_key(cmd_key), .cmd_port(cmd_port), .cmd_nonce(cmd_nonce),
    .cmd_ptr(cmd_ptr), .cfg_life(cfg_life), .res_valid(res_valid), .res_hit(res_hit),
    .res_loop(res_loop), .res_full(res_full), .res_ports(res_ports), .res_ptr(res_ptr)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic        mv [2][NB];
  logic [31:0] mkey [2][NB];
  logic [31:0] mptr [2][NB];
  logic [15:0] mnonce [2][NB];
  logic [15:0] mports [2][NB];
  logic [15:0] mexp [2][NB];
  logic [15:0] mnow = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [31:0] u, input int a1, input int a0);
    return {u[25:0], 3'(a1), 3'(a0)};
  endfunction

  function automatic bit m_live(input int t, input int i);
    logic signed [15:0] d;
    d = mnow - mexp[t][i];
    return mv[t][i] && !(d > 0);
  endfunction

  task automatic m_tick();
    mnow = mnow + 1'b1;
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < NB; i++)
        if (mv[t][i] && !m_live(t, i)) mv[t][i] = 1'b0;
  endtask

  task automatic model(input logic [1:0] op, input logic [31:0] key, input logic [3:0] port,
                       input logic [15:0] nonce, input logic [31:0] ptr,
                       output logic [50:0] er, output int elat);
    int a0, a1, t, i;
    bit l0, l1, m0, m1, ehit, eloop, efull;
    logic [15:0] eports;
    logic [31:0] eptr;
    a0 = int'(key[2:0]); a1 = int'(key[5:3]);
    ehit = 0; eloop = 0; efull = 0; eports = '0; eptr = '0;
    if (op[1]) begin
      m_tick();
      elat = 1;
    end else begin
      l0 = m_live(0, a0); l1 = m_live(1, a1);
      m0 = l0 && mkey[0][a0] == key;
      m1 = l1 && mkey[1][a1] == key;
      elat = m0 ? 2 : 3;
      ehit = m0 || m1;
      t = m0 ? 0 : 1; i = m0 ? a0 : a1;
      if (op[0] == 1'b0) begin
        if (ehit) begin
          if (mnonce[t][i] == nonce) eloop = 1;
          else mports[t][i] = mports[t][i] | (16'd1 << port);
        end else if (!l0 || !l1) begin
          t = l0 ? 1 : 0; i = l0 ? a1 : a0;
          mv[t][i] = 1'b1; mkey[t][i] = key; mptr[t][i] = ptr;
          mnonce[t][i] = nonce; mports[t][i] = 16'd1 << port;
          mexp[t][i] = mnow + cfg_life;
        end else efull = 1;
      end else if (ehit) begin
        eports = mports[t][i]; eptr = mptr[t][i]; mv[t][i] = 1'b0;
      end
    end
    er = {ehit, eloop, efull, eports, eptr};
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [31:0] key, input logic [3:0] port,
                        input logic [15:0] nonce, input logic [31:0] ptr, input string tag);
    logic [50:0] er, ar;
    int elat, lat;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R10 ready before command", 64'(cmd_ready), 64'd1);
    model(op, key, port, nonce, ptr, er, elat);
    cmd_valid = 1'b1; cmd_op = op; cmd_key = key; cmd_port = port;
    cmd_nonce = nonce; cmd_ptr = ptr;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    while (!res_valid && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    ar = {res_hit, res_loop, res_full, res_ports, res_ptr};
    chk(ar == er, tag, 64'(ar), 64'(er));
    chk(lat == elat, "R10 latency", 64'(lat), 64'(elat));
  endtask

  task automatic tick_run(input int n);
    int bad;
    bad = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2;
    repeat (n) begin
      @(negedge clk);
      m_tick();
      if (!res_valid || !cmd_ready || res_hit || res_full || res_loop) bad++;
    end
    cmd_valid = 1'b0;
    chk(bad == 0, "R11 tick stream results", 64'(bad), 64'd0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20.0 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] ka, kb, kc, kd, ke, kf, kw;
    logic [31:0] pool [10];
    void'($urandom(32'd20240611));
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < NB; i++) mv[t][i] = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready after reset", 64'(cmd_ready), 64'd1);
    chk(res_valid == 1'b0, "R1 no result in reset", 64'(res_valid), 64'd0);
    rst_n = 1'b1;
    idle(2);
    chk(cmd_ready == 1'b1 && res_valid == 1'b0, "R1 idle after reset",
        64'({cmd_ready, res_valid}), 64'b10);

    ka = mk(32'h0ABC, 2, 5);
    kb = mk(32'h0123, 6, 5);
    kc = mk(32'h0777, 6, 5);
    kd = mk(32'h1ABC, 2, 5);
    do_cmd(2'd1, ka, 0, 0, 0, "R1 response on empty table misses");
    cfg_life = 16'd100;
    do_cmd(2'd0, ka, 4'd3, 16'd7, 32'hA0A0, "R3 insert into sub-table 0");
    do_cmd(2'd0, ka, 4'd9, 16'd8, 32'h0, "R5 merge second port");
    do_cmd(2'd0, kb, 4'd1, 16'd2, 32'hB0B0, "R3 insert into sub-table 1");
    do_cmd(2'd0, kb, 4'd2, 16'd3, 32'h0, "R5 hit in sub-table 1");
    do_cmd(2'd0, kc, 4'd5, 16'd4, 32'hC0C0, "R4 both buckets live gives full");
    do_cmd(2'd1, kc, 0, 0, 0, "R4 refused insert left nothing");
    do_cmd(2'd0, ka, 4'd12, 16'd7, 32'h0, "R6 repeated nonce is a loop");
    do_cmd(2'd1, kb, 0, 0, 0, "R7 response frees sub-table 1 entry");
    do_cmd(2'd0, kd, 4'd14, 16'd9, 32'hD0D0, "R2 same indices other bits no match");
    do_cmd(2'd1, kd, 0, 0, 0, "R2 response returns only its own entry");
    do_cmd(2'd1, ka, 0, 0, 0, "R7 response returns merged ports");
    do_cmd(2'd1, ka, 0, 0, 0, "R7 second response misses");
    do_cmd(2'd2, 0, 0, 0, 0, "R11 tick result all zero");

    cfg_life = 16'd3;
    ke = mk(32'h0E0E, 1, 1);
    kf = mk(32'h0F0F, 3, 3);
    do_cmd(2'd0, ke, 4'd0, 16'd1, 32'hE, "R3 insert expiry case");
    do_cmd(2'd0, kf, 4'd6, 16'd1, 32'hF, "R3 insert expiry case");
    tick_run(3);
    do_cmd(2'd1, kf, 0, 0, 0, "R8 live on expiry tick");
    tick_run(1);
    do_cmd(2'd1, ke, 0, 0, 0, "R8 absent one tick after expiry");

    for (int j = 0; j < 10; j++) pool[j] = mk($urandom, j % 4, j % 2);
    for (int n = 0; n < 500; n++) begin
      int r;
      r = int'($urandom % 20);
      if (n % 50 == 0) cfg_life = 16'(5 + $urandom % 30);
      if (r < 9)
        do_cmd(2'd0, pool[$urandom % 10], 4'($urandom), 16'(1 + $urandom % 3),
               $urandom, "R5 random request");
      else if (r < 16)
        do_cmd(2'd1, pool[$urandom % 10], 0, 0, 0, "R7 random response");
      else
        do_cmd(2'd2, 0, 0, 0, 0, "R8 random tick");
    end

    idle(20);
    tick_run(100);
    idle(2 * NB + 4);
    cfg_life = 16'd2;
    kw = mk(32'h0D0D, 4, 7);
    do_cmd(2'd0, kw, 4'd2, 16'd5, 32'h5, "R3 insert wrap case");
    tick_run(3);
    idle(2 * NB + 4);
    tick_run(32768);
    do_cmd(2'd1, kw, 0, 0, 0, "R9 swept entry stays gone after wrap");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule